// File: doc/BRIEF.md
# Open-Page DRAM Command Sequencer

This block sits between user logic and the physical interface of a DDR4-class memory controller. It takes one request at a time. Each request arrives already split into bank group, bank, row and column. The block turns the request into the command-pin pattern the memory expects. It keeps the open-row state of every bank, so a request that lands on the row already held in that bank's sense amplifiers goes straight to the column command.

A request that targets a closed bank first gets an activate. A request that targets a different row in an open bank first gets a precharge, then an activate. Each column command is either a plain read or write, which leaves the row open, or the auto-precharge form, which closes the row. The requester picks the form for each request through a close-page flag.

Three fixed minimum spacings, counted in clocks, are enforced:
- activate to column command, per bank;
- precharge or auto-precharge to the next activate, per bank;
- between any two column commands.

A request is accepted in the cycle its column command is decided. On every cycle that carries no command, the pins show a deselect.

Top module: `dram_cmd_seq`

## Requirements
- R1: While reset is low, and in the first cycle after it, the pins show deselect and `req_ready` is low. Deselect means: chip select, activate, RAS, CAS and WE all high, with address, bank group and bank all zero.
- R2: A request to a bank with no open row produces an activate one clock after the decision. The activate has chip select and activate low, and carries bank group and bank. The address carries row bits 13:0. The RAS, CAS and WE pins carry row bits 16, 15 and 14 (zero-extended). The bank is then recorded as open on that row.
- R3: A request whose row matches the bank's open row issues its column command with no activate or precharge before it.
- R4: A request to an open bank with a different row produces a precharge first. The precharge has chip select low, activate high, RAS low, CAS high, WE low and A10 low, and carries the bank. An activate to the new row follows, then the column command.
- R5: A column command has chip select low, activate high, RAS high and CAS low. WE is low for a write and high for a read. Address bits 9:0 carry the column. A10 equals the close-page flag. A12 is high for an 8-beat burst and low when the chop flag asks for 4 beats. All other address bits are zero.
- R6: A column command with the close-page flag set clears that bank's open-row record. A later request to the same row gets an activate with no precharge before it.
- R7: Minimum spacings are enforced. A column command comes at least `T_RCD` clocks after the activate to its bank. An activate comes at least `T_RP` clocks after a precharge or auto-precharge column command to its bank. Two column commands are at least `T_CCD` clocks apart. Each command is issued at the first cycle its spacing allows.
- R8: Every cycle that issues no command drives deselect.
- R9: `req_ready` is high only in the cycle the request's column command is decided. It stays low through precharge, activate and waiting cycles.
- R10: Commands to one bank leave the open-row records of all other banks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bg | input | BG_W | Target bank group |
| req_ba | input | BA_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Starting column |
| req_close | input | 1 | Use the auto-precharge column command |
| req_chop | input | 1 | 4-beat burst instead of 8 |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_act_n | output | 1 | Activate pin, active low |
| dram_ras_n | output | 1 | RAS pin (row bit 16 during activate) |
| dram_cas_n | output | 1 | CAS pin (row bit 15 during activate) |
| dram_we_n | output | 1 | WE pin (row bit 14 during activate) |
| dram_bg | output | BG_W | Bank group pins |
| dram_ba | output | BA_W | Bank pins |
| dram_addr | output | 14 | Address pins A13..A0 |

## Verification
A stale open-row record shows at the pins within one request. It appears either as a missing activate, which is a column command to a row never opened, or as a redundant precharge or activate before a page hit. It is visible one clock after the decision.

A spacing counter that is wrong by one shifts a column command or an activate by a cycle. The bench model predicts the exact issue cycle, so that shift is caught on the cycle it happens.

A wrong acceptance shows the same cycle on `req_ready`, and the next cycle as a missing or extra column command.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    C_DES = 3'd0,
    C_ACT = 3'd1,
    C_PRE = 3'd2,
    C_RD  = 3'd3,
    C_WR  = 3'd4
  } dcmd_e;

  localparam int ADDR_W  = 14;
  localparam int AP_BIT  = 10;
  localparam int BL_BIT  = 12;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // value to preload so a counter reaches zero exactly gap clocks later
  function automatic int gap_preload(input int gap);
    return (gap > 0) ? gap - 1 : 0;
  endfunction

endpackage

// File: rtl/dram_gap_timer.sv
module dram_gap_timer #(
  parameter int GAP_W = 3,
  parameter int LOAD  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic ready
);
  logic [GAP_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (fire)         cnt_q <= GAP_W'(LOAD);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign ready = (cnt_q == '0);
endmodule

// File: rtl/dram_bank_table.sv
module dram_bank_table #(
  parameter int NB       = 16,
  parameter int ROW_W    = 15,
  parameter int GAP_W    = 3,
  parameter int RCD_LOAD = 3,
  parameter int RP_LOAD  = 2,
  localparam int IW      = $clog2(NB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IW-1:0]    idx,
  input  logic             act_en,
  input  logic             close_en,
  input  logic [ROW_W-1:0] act_row,
  output logic             sel_open,
  output logic [ROW_W-1:0] sel_row,
  output logic             sel_idle
);
  logic             open_all [NB];
  logic [ROW_W-1:0] row_all  [NB];
  logic             idle_all [NB];

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic             open_q;
    logic [ROW_W-1:0] row_q;
    logic [GAP_W-1:0] wait_q;
    logic             hit_me;

    assign hit_me = (idx == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q <= 1'b0;
        row_q  <= '0;
        wait_q <= '0;
      end else if (hit_me && act_en) begin
        open_q <= 1'b1;
        row_q  <= act_row;
        wait_q <= GAP_W'(RCD_LOAD);
      end else if (hit_me && close_en) begin
        open_q <= 1'b0;
        wait_q <= GAP_W'(RP_LOAD);
      end else if (wait_q != '0) begin
        wait_q <= wait_q - 1'b1;
      end
    end

    assign open_all[g] = open_q;
    assign row_all[g]  = row_q;
    assign idle_all[g] = (wait_q == '0);
  end

  assign sel_open = open_all[idx];
  assign sel_row  = row_all[idx];
  assign sel_idle = idle_all[idx];

  AST_OPEN_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    act_en |=> open_all[$past(idx)]); // R2
  AST_SHUT_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    close_en |=> !open_all[$past(idx)]); // R6
endmodule

// File: rtl/dram_pin_enc.sv
module dram_pin_enc
  import dram_seq_pkg::*;
#(
  parameter int BG_W  = 2,
  parameter int BA_W  = 2,
  parameter int ROW_W = 15,
  parameter int COL_W = 10
) (
  input  dcmd_e             cmd,
  input  logic [BG_W-1:0]   bg,
  input  logic [BA_W-1:0]   ba,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  input  logic              ap,
  input  logic              chop,
  output logic              cs_n,
  output logic              act_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BG_W-1:0]   bg_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr
);
  logic [16:0]        row_x;
  logic [ADDR_W-1:0]  col_x;

  assign row_x = 17'(row);
  assign col_x = ADDR_W'(col);

  always_comb begin
    cs_n  = 1'b1; act_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    bg_o  = '0;   ba_o  = '0;   addr  = '0;
    case (cmd)
      C_ACT: begin
        cs_n = 1'b0; act_n = 1'b0;
        ras_n = row_x[16]; cas_n = row_x[15]; we_n = row_x[14];
        addr = row_x[ADDR_W-1:0];
        bg_o = bg; ba_o = ba;
      end
      C_PRE: begin
        cs_n = 1'b0; ras_n = 1'b0; we_n = 1'b0;
        bg_o = bg; ba_o = ba;
      end
      C_RD, C_WR: begin
        cs_n = 1'b0; cas_n = 1'b0;
        we_n = (cmd == C_RD);
        addr = col_x;
        addr[AP_BIT] = ap;
        addr[BL_BIT] = ~chop;
        bg_o = bg; ba_o = ba;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq
  import dram_seq_pkg::*;
#(
  parameter int BG_W  = 2,
  parameter int BA_W  = 2,
  parameter int ROW_W = 15,
  parameter int COL_W = 10,
  parameter int T_RCD = 4,
  parameter int T_RP  = 3,
  parameter int T_CCD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [BG_W-1:0]  req_bg,
  input  logic [BA_W-1:0]  req_ba,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             req_close,
  input  logic             req_chop,
  output logic             dram_cs_n,
  output logic             dram_act_n,
  output logic             dram_ras_n,
  output logic             dram_cas_n,
  output logic             dram_we_n,
  output logic [BG_W-1:0]  dram_bg,
  output logic [BA_W-1:0]  dram_ba,
  output logic [13:0]      dram_addr
);
  localparam int IW    = BG_W + BA_W;
  localparam int NB    = 1 << IW;
  localparam int GAP_W = $clog2(max3(T_RCD, T_RP, T_CCD) + 1);
  localparam int SW    = GAP_W + 1;

  logic [IW-1:0]    bank_idx;
  logic             sel_open, sel_idle, ccd_ready;
  logic [ROW_W-1:0] sel_row;
  logic             is_hit, is_miss, is_closed;
  logic             issue_act, issue_pre, issue_col, close_en;
  dcmd_e            nxt_cmd;

  logic             e_cs, e_act, e_ras, e_cas, e_we;
  logic [BG_W-1:0]  e_bg;
  logic [BA_W-1:0]  e_ba;
  logic [13:0]      e_addr;

  assign bank_idx  = {req_bg, req_ba};
  assign is_hit    = req_valid && sel_open && (sel_row == req_row);
  assign is_miss   = req_valid && sel_open && (sel_row != req_row);
  assign is_closed = req_valid && !sel_open;

  assign issue_col = is_hit && sel_idle && ccd_ready;
  assign issue_pre = is_miss && sel_idle;
  assign issue_act = is_closed && sel_idle;
  assign close_en  = issue_pre || (issue_col && req_close);
  assign req_ready = issue_col;

  always_comb begin
    nxt_cmd = C_DES;
    if (issue_act)      nxt_cmd = C_ACT;
    else if (issue_pre) nxt_cmd = C_PRE;
    else if (issue_col) nxt_cmd = req_write ? C_WR : C_RD;
  end

  dram_bank_table #(
    .NB(NB), .ROW_W(ROW_W), .GAP_W(GAP_W),
    .RCD_LOAD(gap_preload(T_RCD)), .RP_LOAD(gap_preload(T_RP))
  ) u_banks (
    .clk(clk), .rst_n(rst_n), .idx(bank_idx),
    .act_en(issue_act), .close_en(close_en), .act_row(req_row),
    .sel_open(sel_open), .sel_row(sel_row), .sel_idle(sel_idle)
  );

  dram_gap_timer #(.GAP_W(GAP_W), .LOAD(gap_preload(T_CCD))) u_ccd (
    .clk(clk), .rst_n(rst_n), .fire(issue_col), .ready(ccd_ready)
  );

  dram_pin_enc #(.BG_W(BG_W), .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_enc (
    .cmd(nxt_cmd), .bg(req_bg), .ba(req_ba), .row(req_row), .col(req_col),
    .ap(req_close), .chop(req_chop),
    .cs_n(e_cs), .act_n(e_act), .ras_n(e_ras), .cas_n(e_cas), .we_n(e_we),
    .bg_o(e_bg), .ba_o(e_ba), .addr(e_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dram_cs_n  <= 1'b1; dram_act_n <= 1'b1; dram_ras_n <= 1'b1;
      dram_cas_n <= 1'b1; dram_we_n  <= 1'b1;
      dram_bg <= '0; dram_ba <= '0; dram_addr <= '0;
    end else begin
      dram_cs_n  <= e_cs;  dram_act_n <= e_act; dram_ras_n <= e_ras;
      dram_cas_n <= e_cas; dram_we_n  <= e_we;
      dram_bg <= e_bg; dram_ba <= e_ba; dram_addr <= e_addr;
    end
  end

  // pin-level event decode for the checks below
  logic          act_pin, pre_pin, col_pin;
  logic [SW-1:0] since_col;

  assign act_pin = !dram_cs_n && !dram_act_n;
  assign pre_pin = !dram_cs_n && dram_act_n && !dram_ras_n && dram_cas_n && !dram_we_n;
  assign col_pin = !dram_cs_n && dram_act_n && dram_ras_n && !dram_cas_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_col <= '1;
    else if (col_pin)        since_col <= SW'(1);
    else if (since_col != '1) since_col <= since_col + 1'b1;
  end

  AST_READY_GIVES_COL: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> col_pin); // R9
  AST_CCD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    col_pin |-> (since_col >= SW'(T_CCD))); // R7
  AST_RCD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ((T_RCD > 1) && act_pin) |=> !(col_pin && dram_bg == $past(dram_bg) && dram_ba == $past(dram_ba))); // R7
  AST_PRE_NOT_COL: assert property (@(posedge clk) disable iff (!rst_n)
    pre_pin |=> !(col_pin && dram_bg == $past(dram_bg) && dram_ba == $past(dram_ba))); // R4
endmodule

// File: tb/dram_cmd_seq_bench.sv
module dram_cmd_seq_bench;
  localparam int T_RCD = 4;
  localparam int T_RP  = 3;
  localparam int T_CCD = 2;
  localparam int PW    = 5 + 4 + 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_close = 1'b0, req_chop = 1'b0;
  logic [1:0] req_bg = '0, req_ba = '0;
  logic [14:0] req_row = '0;
  logic [9:0] req_col = '0;
  logic req_ready;
  logic dram_cs_n, dram_act_n, dram_ras_n, dram_cas_n, dram_we_n;
  logic [1:0] dram_bg, dram_ba;
  logic [13:0] dram_addr;

  always #5 clk = ~clk;

  dram_cmd_seq u_dram_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bg(req_bg), .req_ba(req_ba), .req_row(req_row),
    .req_col(req_col), .req_close(req_close), .req_chop(req_chop),
    .dram_cs_n(dram_cs_n), .dram_act_n(dram_act_n), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_bg(dram_bg),
    .dram_ba(dram_ba), .dram_addr(dram_addr)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0, wd = 0;
  int act_cnt = 0, pre_cnt = 0;
  int act_at = 0, pre_at = 0, col_at = 0, col_prev = 0;

  // behavioural model state
  bit ov [16];
  int orow [16];
  int last_act [16];
  int last_close [16];
  int last_col;
  logic [PW-1:0] exp_q;
  int exp_kind;

  function automatic logic [PW-1:0] enc(input int kind, input int b, input int row,
                                        input int col, input bit ap, input bit ch);
    logic [4:0] c;
    logic [13:0] a;
    logic [3:0] bb;
    c = 5'b11111; a = '0; bb = 4'(b);
    case (kind)
      1: begin c = {2'b00, row[16], row[15], row[14]}; a = row[13:0]; end
      2: c = 5'b01010;
      3, 4: begin
        c = (kind == 3) ? 5'b01101 : 5'b01100;
        a = 14'(col[9:0]); a[10] = ap; a[12] = !ch;
      end
      default: bb = 4'd0;
    endcase
    return {c, bb, a};
  endfunction

  function automatic string req_of(input int kind);
    case (kind)
      1: return "R2";
      2: return "R4";
      3, 4: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input longint got, input longint want);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", rq, what, got, want);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  logic [PW-1:0] pins;
  assign pins = {dram_cs_n, dram_act_n, dram_ras_n, dram_cas_n, dram_we_n, dram_bg, dram_ba, dram_addr};

  function automatic bit bank_ok(input int b);
    return (cyc - last_act[b] >= T_RCD) && (cyc - last_close[b] >= T_RP);
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin
        ov[i] = 0; orow[i] = 0; last_act[i] = -1000; last_close[i] = -1000;
      end
      last_col = -1000;
      cyc = 0;
      check(pins === enc(0, 0, 0, 0, 0, 0), "R1", "pins in reset", pins, enc(0, 0, 0, 0, 0, 0));
      exp_q = enc(0, 0, 0, 0, 0, 0); exp_kind = 0;
    end else begin
      int b, kind;
      bit rdy;
      check(pins === exp_q, req_of(exp_kind), "pins", pins, exp_q);
      if (!dram_cs_n && !dram_act_n) begin act_cnt++; act_at = cyc; end
      if (!dram_cs_n && dram_act_n && !dram_ras_n && dram_cas_n) begin pre_cnt++; pre_at = cyc; end
      if (!dram_cs_n && dram_act_n && dram_ras_n && !dram_cas_n) begin col_prev = col_at; col_at = cyc; end
      b = {req_bg, req_ba}; kind = 0; rdy = 0;
      if (req_valid) begin
        if (ov[b] && orow[b] == int'(req_row)) begin
          if (bank_ok(b) && cyc - last_col >= T_CCD) begin
            kind = req_write ? 4 : 3; rdy = 1; last_col = cyc;
            if (req_close) begin ov[b] = 0; last_close[b] = cyc; end
          end
        end else if (ov[b]) begin
          if (bank_ok(b)) begin kind = 2; ov[b] = 0; last_close[b] = cyc; end
        end else if (bank_ok(b)) begin
          kind = 1; ov[b] = 1; orow[b] = int'(req_row); last_act[b] = cyc;
        end
      end
      check(req_ready === rdy, "R9", "req_ready", req_ready, rdy);
      exp_q = enc(kind, b, int'(req_row), int'(req_col), req_close, req_chop);
      exp_kind = kind;
      cyc++;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL R8 watchdog: got cycles=%0d expected below 20000", wd);
      summary();
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic send(input bit w, input int bg, input int ba, input int row,
                      input int col, input bit cl, input bit ch);
    bit got;
    req_valid = 1; req_write = w; req_bg = 2'(bg); req_ba = 2'(ba);
    req_row = 15'(row); req_col = 10'(col); req_close = cl; req_chop = ch;
    got = 0;
    while (!got) begin
      @(negedge clk); got = req_ready;
      @(posedge clk); #1;
    end
    req_valid = 0;
  endtask

  initial begin
    int a0, p0, seed;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req_ready === 1'b0, "R1", "ready in reset", req_ready, 0);
    @(posedge clk); #1;
    rst_n = 1;
    idle(1);
    check(pins === enc(0, 0, 0, 0, 0, 0), "R1", "pins after reset", pins, enc(0, 0, 0, 0, 0, 0));

    // closed bank: activate, wait tRCD, read
    send(0, 0, 0, 5, 0, 0, 0); idle(2);
    check(act_cnt == 1, "R2", "activates", act_cnt, 1);
    check(col_at - act_at == T_RCD, "R7", "act to col gap", col_at - act_at, T_RCD);

    // page hits: plain write then write with auto-precharge
    a0 = act_cnt;
    send(1, 0, 0, 5, 8, 0, 0);
    send(1, 0, 0, 5, 16, 1, 0); idle(2);
    check(act_cnt == a0, "R3", "no activate on hits", act_cnt, a0);

    // closed by auto-precharge: activate, no precharge
    a0 = act_cnt; p0 = pre_cnt;
    send(0, 0, 0, 5, 24, 0, 1); idle(2);
    check(pre_cnt == p0, "R6", "no precharge after auto close", pre_cnt, p0);
    check(act_cnt == a0 + 1, "R6", "reactivate after auto close", act_cnt, a0 + 1);

    // row miss: precharge, activate, read
    a0 = act_cnt; p0 = pre_cnt;
    send(0, 0, 0, 9, 0, 0, 0); idle(2);
    check(pre_cnt == p0 + 1, "R4", "precharge on miss", pre_cnt, p0 + 1);
    check(act_cnt == a0 + 1, "R4", "activate on miss", act_cnt, a0 + 1);
    check(act_at - pre_at == T_RP, "R7", "pre to act gap", act_at - pre_at, T_RP);

    // high row bit on the WE pin, chopped burst
    send(1, 1, 1, 'h4abc, 4, 0, 1);
    // back-to-back column commands
    send(0, 1, 1, 'h4abc, 8, 0, 0);
    send(0, 1, 1, 'h4abc, 16, 0, 0); idle(2);
    check(col_at - col_prev == T_CCD, "R7", "col to col gap", col_at - col_prev, T_CCD);

    // bank independence
    a0 = act_cnt;
    send(0, 0, 0, 9, 32, 0, 0);
    send(1, 1, 1, 'h4abc, 0, 0, 0); idle(2);
    check(act_cnt == a0, "R10", "both banks still open", act_cnt, a0);

    idle(4);
    seed = 7;
    for (int i = 0; i < 40; i++) begin
      int bk, rw;
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      bk = (seed >> 4) % 3;
      rw = (seed >> 8) % 3;
      send(seed[2], (bk == 2) ? 2 : bk, (bk == 2) ? 2 : bk, (rw == 0) ? 5 : (rw == 1) ? 9 : 'h4abc,
           (seed >> 12) & 10'h3f8, (i % 5) == 0, (i % 3) == 0);
      if (seed[3]) idle(1);
    end
    idle(4);
    summary();
    $finish;
  end
endmodule